// File: doc/BRIEF.md
# Multi-Pattern Bit Error Rate Test Source

This block drives the transmit side of a bit error rate test on a T1/E1-class link. Each time the bit enable is high it shifts out one test bit. A four-bit select input chooses what is sent.

The choices fall into two groups:
- Maximal-length pseudo-random sequences of period 2^11-1, 2^20-1 and 2^23-1.
- A quasi-random mode that takes the 20-stage sequence and never lets more than fourteen zeros go out in a row.
- Fixed repeating patterns: steady ones, steady zeros, alternating, one mark per octet, two marks per octet, and a 440-bit stress pattern that holds a single 15-zero run.

A change of selection waits until the next octet boundary of the bit stream. It then starts the new pattern from its first bit. A rising edge on the error strobe inverts exactly one transmitted bit, so the far-end checker can be shown to count errors.

Top module: `bert_pattern_gen`

## Requirements
- R1: After reset `bit_out` is 0, the active pattern is steady ones (code 0) and the bit position inside the octet is 0.
- R2: `bit_out` changes only on a clock edge where `bit_en` is high; otherwise it holds its value.
- R3: Select codes 0, 1 and 2 give steady ones, steady zeros, and alternation starting with a one (1,0,1,0,...).
- R4: Code 3 repeats the octet 1,0,0,0,0,0,0,0. Code 4 repeats 0,1,0,0,0,0,1,0, so no zero run is longer than four. Both are listed first bit first.
- R5: Code 5 repeats a 440-bit sequence made of 55 octets, each sent most significant bit first. Octet 20 is 0x80, octet 21 is 0x00 and octet 22 is 0xFF. The other odd octets are 0xC3 and the other even octets are 0x55. The longest zero run is therefore exactly 15.
- R6: Codes 6, 7 and 8 send the most significant bit of an 11-, 20- or 23-bit shift register. On each bit the register shifts toward its top, and the bit entering the bottom is the exclusive-or of the top bit with bit 8, 16 or 17 respectively (taps x^11+x^9+1, x^20+x^17+1, x^23+x^18+1). Every register starts from all ones, so each period holds 2^(n-1) ones.
- R7: Code 9 sends the 20-bit sequence of R6, except that a one replaces any zero that would be the fifteenth in a row. The register keeps stepping as usual.
- R8: A new select value is taken up only on a bit whose octet position is 0. That bit is the first bit of the new pattern. Codes 10 to 15 send zeros.
- R9: A rising edge of `err_inject` inverts the next bit sent, which may be the bit sent on the same edge. Only that one bit is inverted, however long the strobe stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Send one bit on this edge |
| pat_sel | input | 4 | Pattern code (see R3 to R8) |
| err_inject | input | 1 | Error strobe; each rising edge corrupts one bit |
| bit_out | output | 1 | Serial test bit |

## Verification
The bench builds the block with its default parameters: a 14-zero limit and registers of 11, 20 and 23 stages. These values let a run cover two full periods of the short sequence, two full passes of the 440-bit stress pattern and about a tenth of the quasi-random period. Because of that, the period and the count of ones are checked on the actual output, and the longest zero run is measured in both the stress mode and the quasi-random mode. The stall of a select change that arrives in the middle of an octet, and the inversion rule for a strobe that is held high, are checked bit by bit.

// File: rtl/bert_pkg.sv
package bert_pkg;

  localparam int SEL_W         = 4;
  localparam int GROUP_BITS    = 8;
  localparam int GRP_W         = $clog2(GROUP_BITS);
  localparam int STRESS_OCTETS = 55;
  localparam int STRESS_BITS   = GROUP_BITS * STRESS_OCTETS;
  localparam int NUM_PN        = 3;

  localparam logic [SEL_W-1:0] PAT_ONES  = 4'd0;
  localparam logic [SEL_W-1:0] PAT_ZEROS = 4'd1;
  localparam logic [SEL_W-1:0] PAT_ALT   = 4'd2;
  localparam logic [SEL_W-1:0] PAT_1IN8  = 4'd3;
  localparam logic [SEL_W-1:0] PAT_2IN8  = 4'd4;
  localparam logic [SEL_W-1:0] PAT_OCT55 = 4'd5;
  localparam logic [SEL_W-1:0] PAT_PN11  = 4'd6;
  localparam logic [SEL_W-1:0] PAT_PN20  = 4'd7;
  localparam logic [SEL_W-1:0] PAT_PN23  = 4'd8;
  localparam logic [SEL_W-1:0] PAT_QRSS  = 4'd9;

  // Octet k of the long stress pattern: three special octets make one 15-zero run
  function automatic logic [7:0] stress_octet(input int unsigned k);
    if (k == 20)          return 8'h80;
    else if (k == 21)     return 8'h00;
    else if (k == 22)     return 8'hFF;
    else if ((k % 2) == 1) return 8'hC3;
    else                  return 8'h55;
  endfunction

endpackage

// File: rtl/bert_lfsr.sv
module bert_lfsr #(
  parameter int LEN = 11,
  parameter int TAP = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic restart,
  output logic msb_bit
);

  localparam logic [LEN-1:0] SEED = '1;

  logic [LEN-1:0] state_q;
  logic [LEN-1:0] cur;

  function automatic logic [LEN-1:0] advance(input logic [LEN-1:0] s);
    return {s[LEN-2:0], s[LEN-1] ^ s[TAP-1]};
  endfunction

  // a restart emits the seed's top bit in the same cycle
  assign cur     = restart ? SEED : state_q;
  assign msb_bit = cur[LEN-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state_q <= SEED;
    else if (step) state_q <= advance(cur);
  end

endmodule

// File: rtl/bert_fixed_pat.sv
module bert_fixed_pat
  import bert_pkg::*;
#(
  parameter int POS_W = 9
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [POS_W-1:0] pos,
  output logic             fixed_bit
);

  logic [GRP_W-1:0] slot;
  logic [7:0]       octet;

  assign slot  = pos[GRP_W-1:0];
  assign octet = stress_octet(int'(pos[POS_W-1:GRP_W]));

  always_comb begin
    unique case (sel)
      PAT_ONES:  fixed_bit = 1'b1;
      PAT_ZEROS: fixed_bit = 1'b0;
      PAT_ALT:   fixed_bit = ~slot[0];
      PAT_1IN8:  fixed_bit = (slot == 3'd0);
      PAT_2IN8:  fixed_bit = (slot == 3'd1) || (slot == 3'd6);
      PAT_OCT55: fixed_bit = octet[3'd7 - slot];
      default:   fixed_bit = 1'b0;
    endcase
  end

endmodule

// File: rtl/bert_pattern_gen.sv
module bert_pattern_gen
  import bert_pkg::*;
#(
  parameter int MAX_ZERO_RUN = 14,
  parameter int PN_A_LEN     = 11,
  parameter int PN_A_TAP     = 9,
  parameter int PN_B_LEN     = 20,
  parameter int PN_B_TAP     = 17,
  parameter int PN_C_LEN     = 23,
  parameter int PN_C_TAP     = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic [SEL_W-1:0] pat_sel,
  input  logic             err_inject,
  output logic             bit_out
);

  localparam int                POS_W      = $clog2(STRESS_BITS);
  localparam logic [POS_W-1:0]  POS_LAST   = POS_W'(STRESS_BITS - 1);
  localparam int                ZRUN_W     = $clog2(MAX_ZERO_RUN + 2);
  localparam logic [ZRUN_W-1:0] ZRUN_LIMIT = ZRUN_W'(MAX_ZERO_RUN);
  localparam logic [ZRUN_W-1:0] ZRUN_SAT   = '1;

  logic [SEL_W-1:0]  act_sel_q, sel_now;
  logic [POS_W-1:0]  pos_q, pos_now;
  logic [ZRUN_W-1:0] zrun_q, zrun_now, zrun_next;
  logic              at_boundary, reload_evt, fixed_bit, raw_bit, pat_bit, force_one_evt;
  logic              inj_q, pend_q, inj_rise, flip_evt;
  logic [NUM_PN-1:0] pn_bits;

  // selection switch-over, only at an octet boundary
  assign at_boundary = (pos_q[GRP_W-1:0] == '0);
  assign reload_evt  = bit_en && at_boundary && (pat_sel != act_sel_q);
  assign sel_now     = reload_evt ? pat_sel : act_sel_q;
  assign pos_now     = reload_evt ? '0 : pos_q;
  assign zrun_now    = reload_evt ? '0 : zrun_q;

  for (genvar g = 0; g < NUM_PN; g++) begin : g_pn
    localparam int LEN = (g == 0) ? PN_A_LEN : (g == 1) ? PN_B_LEN : PN_C_LEN;
    localparam int TAP = (g == 0) ? PN_A_TAP : (g == 1) ? PN_B_TAP : PN_C_TAP;
    bert_lfsr #(.LEN(LEN), .TAP(TAP)) i_lfsr (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (bit_en),
      .restart (reload_evt),
      .msb_bit (pn_bits[g])
    );
  end

  bert_fixed_pat #(.POS_W(POS_W)) i_fixed (
    .sel       (sel_now),
    .pos       (pos_now),
    .fixed_bit (fixed_bit)
  );

  always_comb begin
    unique case (sel_now)
      PAT_PN11:           raw_bit = pn_bits[0];
      PAT_PN20, PAT_QRSS: raw_bit = pn_bits[1];
      PAT_PN23:           raw_bit = pn_bits[2];
      default:            raw_bit = fixed_bit;
    endcase
  end

  // quasi-random zero-run limit
  assign force_one_evt = bit_en && (sel_now == PAT_QRSS) && (zrun_now == ZRUN_LIMIT) && !raw_bit;
  assign pat_bit       = raw_bit | force_one_evt;
  assign zrun_next     = pat_bit ? '0 :
                         (zrun_now == ZRUN_SAT) ? zrun_now : zrun_now + 1'b1;

  // error strobe: one inverted bit per rising edge
  assign inj_rise = err_inject && !inj_q;
  assign flip_evt = bit_en && (pend_q || inj_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inj_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      inj_q  <= err_inject;
      pend_q <= bit_en ? 1'b0 : (pend_q || inj_rise);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_out   <= 1'b0;
      act_sel_q <= PAT_ONES;
      pos_q     <= '0;
      zrun_q    <= '0;
    end else if (bit_en) begin
      bit_out   <= pat_bit ^ flip_evt;
      act_sel_q <= sel_now;
      pos_q     <= (pos_now == POS_LAST) ? '0 : pos_now + 1'b1;
      zrun_q    <= zrun_next;
    end
  end

endmodule

module bert_pattern_gen_chk
  import bert_pkg::*;
#(
  parameter int MAX_ZERO_RUN = 14,
  parameter int POS_W        = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_en,
  input logic             err_inject,
  input logic             bit_out,
  input logic [SEL_W-1:0] act_sel,
  input logic [SEL_W-1:0] cur_sel,
  input logic [POS_W-1:0] pos,
  input logic             reload_evt,
  input logic             flip_evt,
  input logic             pat_bit
);

  localparam int               QZ_W     = $clog2(MAX_ZERO_RUN + 2) + 1;
  localparam logic [QZ_W-1:0]  QZ_LIMIT = QZ_W'(MAX_ZERO_RUN);
  localparam logic [POS_W-1:0] POS_MAX  = POS_W'(STRESS_BITS - 1);
  localparam logic [POS_W-1:0] POS_ONE  = POS_W'(1);

  logic [QZ_W-1:0] qz;

  // independent count of quasi-random zeros actually emitted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) qz <= '0;
    else if (bit_en) begin
      if (cur_sel == PAT_QRSS && !pat_bit && qz != '1) qz <= qz + 1'b1;
      else if (cur_sel != PAT_QRSS || pat_bit)         qz <= '0;
    end
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(bit_out));

  assert_pos_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= POS_MAX);

  assert_zero_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    qz <= QZ_LIMIT);

  assert_mid_octet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && pos[2:0] != 3'd0) |=> $stable(act_sel));

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reload_evt |=> (pos == POS_ONE));

  assert_single_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flip_evt |=> (!flip_evt || $rose(err_inject)));

endmodule

bind bert_pattern_gen bert_pattern_gen_chk #(
  .MAX_ZERO_RUN (MAX_ZERO_RUN),
  .POS_W        (POS_W)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_en     (bit_en),
  .err_inject (err_inject),
  .bit_out    (bit_out),
  .act_sel    (act_sel_q),
  .cur_sel    (sel_now),
  .pos        (pos_q),
  .reload_evt (reload_evt),
  .flip_evt   (flip_evt),
  .pat_bit    (pat_bit)
);

// File: tb/test_bert_pattern_gen.sv
module test_bert_pattern_gen;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 180000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       err_inject = 1'b0;
  logic [3:0] pat_sel = 4'd0;
  logic       bit_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  bert_pattern_gen i_bert_pattern_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .pat_sel    (pat_sel),
    .err_inject (err_inject),
    .bit_out    (bit_out)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // scoreboard
  bit    exp_q[$];
  string req_q[$];
  bit    seen_q[$];

  // reference state, built from the requirements
  bit          stress[440];
  logic [3:0]  m_act = 4'd0;
  int          m_pos = 0;
  int          m_zr = 0;
  logic [10:0] p11 = '1;
  logic [19:0] p20 = '1;
  logic [22:0] p23 = '1;
  bit          m_pend = 1'b0;
  bit          m_inj = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_bit(output bit b);
    if (pat_sel != m_act && (m_pos % 8) == 0) begin
      m_act = pat_sel; m_pos = 0; m_zr = 0;
      p11 = '1; p20 = '1; p23 = '1;
    end
    case (m_act)
      4'd0: b = 1'b1;
      4'd1: b = 1'b0;
      4'd2: b = (m_pos % 2) == 0;
      4'd3: b = (m_pos % 8) == 0;
      4'd4: b = (m_pos % 8) == 1 || (m_pos % 8) == 6;
      4'd5: b = stress[m_pos];
      4'd6: b = p11[10];
      4'd7: b = p20[19];
      4'd8: b = p23[22];
      4'd9: b = p20[19] || (m_zr == 14);
      default: b = 1'b0;
    endcase
    m_zr = b ? 0 : m_zr + 1;
    p11 = {p11[9:0], p11[10] ^ p11[8]};
    p20 = {p20[18:0], p20[19] ^ p20[16]};
    p23 = {p23[21:0], p23[22] ^ p23[17]};
    m_pos = (m_pos + 1) % 440;
  endtask

  // driver: one clock cycle of stimulus, expected bit pushed when a bit is sent
  task automatic cyc(input bit en, input bit inj, input string req);
    bit rise, flip, b;
    bit_en = en;
    err_inject = inj;
    rise = inj && !m_inj;
    flip = m_pend || rise;
    m_inj = inj;
    if (en) begin
      model_bit(b);
      exp_q.push_back(b ^ flip);
      req_q.push_back(req);
      m_pend = 1'b0;
    end else begin
      m_pend = flip;
    end
    @(negedge clk);
  endtask

  task automatic run_bits(input int n, input string req);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, req);
    cyc(1'b0, 1'b0, "R2");
  endtask

  // monitor
  bit en_seen = 1'b0;
  bit last_val = 1'b0;
  always @(posedge clk) en_seen <= bit_en;

  always @(negedge clk) begin
    if (rst_n) begin
      if (en_seen) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "queue", 1, 0);
        end else begin
          bit e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          check(bit_out == e, r, int'(bit_out), int'(e));
          last_val = e;
          seen_q.push_back(bit_out);
        end
      end else begin
        check(bit_out == last_val, "R2", int'(bit_out), int'(last_val));
      end
    end
  end

  function automatic int longest_zero_run();
    int run = 0, best = 0;
    foreach (seen_q[i]) begin
      run = seen_q[i] ? 0 : run + 1;
      if (run > best) best = run;
    end
    return best;
  endfunction

  initial begin
    int ones, diffs;
    for (int k = 0; k < 55; k++) begin
      logic [7:0] v;
      v = (k == 20) ? 8'h80 : (k == 21) ? 8'h00 : (k == 22) ? 8'hFF :
          (k % 2 == 1) ? 8'hC3 : 8'h55;
      for (int j = 0; j < 8; j++) stress[k*8 + j] = v[7-j];
    end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(bit_out == 1'b0, "R1", int'(bit_out), 0);

    // R1: default pattern is steady ones, with idle gaps for R2
    for (int i = 0; i < 8; i++) begin
      cyc(1'b1, 1'b0, "R1");
      cyc(1'b0, 1'b0, "R2");
    end

    pat_sel = 4'd1; run_bits(16, "R3");
    pat_sel = 4'd2; run_bits(16, "R3");
    pat_sel = 4'd3; run_bits(16, "R4");
    pat_sel = 4'd4; run_bits(16, "R4");

    // R8: change in mid-octet is held until the boundary
    pat_sel = 4'd0; run_bits(3, "R8");
    pat_sel = 4'd2; run_bits(13, "R8");
    pat_sel = 4'd12; run_bits(16, "R8");

    // R5: two passes of the stress pattern
    pat_sel = 4'd5;
    seen_q.delete();
    run_bits(880, "R5");
    check(longest_zero_run() == 15, "R5", longest_zero_run(), 15);
    diffs = 0;
    for (int i = 0; i < 440; i++) if (seen_q[i] != seen_q[i+440]) diffs++;
    check(diffs == 0, "R5", diffs, 0);

    // R6: 11-stage sequence, two periods
    pat_sel = 4'd6;
    seen_q.delete();
    run_bits(4094, "R6");
    ones = 0;
    for (int i = 0; i < 2047; i++) if (seen_q[i]) ones++;
    check(ones == 1024, "R6", ones, 1024);
    diffs = 0;
    for (int i = 0; i < 2047; i++) if (seen_q[i] != seen_q[i+2047]) diffs++;
    check(diffs == 0, "R6", diffs, 0);

    pat_sel = 4'd7; run_bits(3000, "R6");
    pat_sel = 4'd8;
    seen_q.delete();
    run_bits(3000, "R6");
    ones = 0;
    for (int i = 0; i < 23; i++) if (seen_q[i]) ones++;
    check(ones == 23, "R6", ones, 23);

    // R7: quasi-random mode with zero-run limit
    pat_sel = 4'd9;
    seen_q.delete();
    run_bits(100000, "R7");
    check(longest_zero_run() <= 14, "R7", longest_zero_run(), 14);

    // R9: error strobe on steady ones
    pat_sel = 4'd0; run_bits(8, "R9");
    cyc(1'b1, 1'b1, "R9");
    cyc(1'b1, 1'b1, "R9");
    cyc(1'b1, 1'b0, "R9");
    cyc(1'b0, 1'b1, "R9");
    cyc(1'b0, 1'b1, "R9");
    cyc(1'b1, 1'b1, "R9");
    cyc(1'b1, 1'b0, "R9");
    cyc(1'b0, 1'b0, "R2");
    cyc(1'b0, 1'b0, "R2");
    check(exp_q.size() == 0, "R9", exp_q.size(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule